// File: doc/BRIEF.md
# DMA Channel Address/Count Step Unit

This block keeps the address and byte-count registers of a four-channel DMA engine and carries out one transfer step on request. A step picks one channel. Depending on that channel's transfer mode, the step does one of three things: it moves a byte from memory to the channel's I/O port, moves a byte from the I/O port to memory, or moves nothing (verify). In every case it then advances the address and counts the byte off. Arbitration and bus timing sit in a neighbouring block. That neighbour issues `step_req` with a channel number and serves the memory and I/O request/acknowledge pairs that this unit raises.

Completion is recognised when the decremented count wraps to all ones, so a loaded count of N moves N+1 bytes. When the count is already zero at the start of a step, that step is the last one. In that case the channel's sticky status bit is set and `tc` stays high for the duration of the step. When the reload option is on and channel 2 completes, channel 2 is refilled from channel 3's address and count. This allows back-to-back buffers without software action. Registers are loaded a byte at a time through one shared byte pointer, low byte first.

Top module: `dmac_step_unit`

## Requirements
- R1: After reset, every channel address and count reads 0, `status`, `mode_err`, `tc`, `step_busy`, `step_done` and `chan_done` are 0, and the byte pointer selects the low byte.
- R2: A register write (`reg_wr` while not busy) loads the low byte (bits 7:0) when the shared byte pointer is low and the high byte (bits 15:8) when it is high. Every accepted write toggles the pointer whatever channel or register it targets. Writes made while a step is in progress are ignored and do not toggle the pointer.
- R3: Each step in modes 0, 1 or 2 leaves the channel's address one higher and its count one lower, both modulo 2^16.
- R4: When a step starts on a channel whose count is 0, that channel's `status` bit (bit index = channel number) is set and `tc` is high from the cycle after acceptance until the step ends. `tc` is low in the cycle where `step_done` is high.
- R5: `chan_done` pulses together with `step_done` exactly when the step's decremented count is 0xFFFF, so a loaded count N completes on step N+1.
- R6: Mode value 0 (verify) raises no memory or I/O request.
- R7: Mode value 1 reads memory at the channel's address, then writes that byte to the I/O port with `io_chan` equal to the channel.
- R8: Mode value 2 reads the I/O port of the channel, then writes that byte to memory at the channel's address.
- R9: When `autoload_en` is 1 and channel 2 completes, channel 2's address and count become channel 3's values and channel 3 is unchanged. With `autoload_en` at 0, channel 2 completes like any other channel.
- R10: Mode value 3 is illegal. Such a step sets the sticky `mode_err` flag, raises no bus request, leaves address, count and `status` unchanged, and still ends with `step_done`.
- R11: `status` bits and `mode_err` are sticky and clear only on the clock edge where `stat_rd` is high. A bit set on that same edge survives the clear.
- R12: At most one bus request is active at a time, none while idle, and `step_req` is ignored while `step_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Byte write strobe for address/count |
| reg_chan | input | 2 | Channel targeted by the byte write |
| reg_is_count | input | 1 | 1 writes the count, 0 the address |
| reg_byte | input | 8 | Byte written |
| mode_wr | input | 1 | Mode write strobe |
| mode_chan | input | 2 | Channel whose mode is written |
| mode_val | input | 2 | 0 verify, 1 memory to I/O, 2 I/O to memory, 3 illegal |
| autoload_en | input | 1 | Reload channel 2 from channel 3 on completion |
| step_req | input | 1 | Start one transfer step |
| step_chan | input | 2 | Channel for the step |
| step_busy | output | 1 | A step is in progress |
| step_done | output | 1 | One-cycle pulse when a step ends |
| chan_done | output | 1 | Step ended with the count wrapping to all ones |
| tc | output | 1 | Terminal-count step in progress |
| stat_rd | input | 1 | Status read; clears sticky flags |
| status | output | 4 | Sticky terminal-count bits, one per channel |
| mode_err | output | 1 | Sticky illegal-mode flag |
| view_chan | input | 2 | Channel whose registers are shown |
| view_addr | output | 16 | Address of view_chan |
| view_count | output | 16 | Count of view_chan |
| mem_addr | output | 16 | Memory address of the active channel |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 8 | Memory read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_ack | input | 1 | Memory write acknowledge |
| mem_wdata | output | 8 | Memory write data |
| io_chan | output | 2 | Channel whose I/O port is accessed |
| io_rd_req | output | 1 | I/O read request |
| io_rd_ack | input | 1 | I/O read acknowledge, data valid |
| io_rdata | input | 8 | I/O read data |
| io_wr_req | output | 1 | I/O write request |
| io_wr_ack | input | 1 | I/O write acknowledge |
| io_wdata | output | 8 | I/O write data |

## Verification
A status read can land on the same clock edge at which a new step is accepted on a channel whose count is zero. The read then clears the sticky bits while the terminal-count detection sets one. The bench provokes this by driving `stat_rd` and `step_req` in the same cycle while an older status bit and the error flag are still set. It expects `status` to hold only the new channel's bit and `mode_err` to be 0. A second overlap is the completion of channel 2 with reload enabled: the increment and the reload compete for the same registers. That case is judged by reading back channel 2 after `step_done` and requiring channel 3's values.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;
  typedef enum logic [1:0] {
    XF_VERIFY = 2'd0,
    XF_MEM2IO = 2'd1,
    XF_IO2MEM = 2'd2,
    XF_BAD    = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } step_st_e;
endpackage

// File: rtl/dmacc_regfile.sv
module dmacc_regfile #(
  parameter int NCH    = 4,
  parameter int BW     = 8,
  parameter int RL_DST = 2,
  parameter int RL_SRC = 3,
  localparam int CW = $clog2(NCH),
  localparam int AW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_is_cnt,
  input  logic [BW-1:0] wr_byte,
  input  logic          upd_en,
  input  logic          reload_en,
  input  logic [CW-1:0] upd_chan,
  input  logic [CW-1:0] sel_chan,
  output logic [AW-1:0] sel_addr,
  output logic [AW-1:0] sel_cnt,
  input  logic [CW-1:0] view_chan,
  output logic [AW-1:0] view_addr,
  output logic [AW-1:0] view_cnt
);
  logic [AW-1:0] addr_v [NCH];
  logic [AW-1:0] cnt_v  [NCH];
  logic          hi_q, hi_n;

  // shared byte pointer
  always_comb hi_n = wr_en ? ~hi_q : hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= 1'b0;
    else if (wr_en) hi_q <= hi_n;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] a_q, a_n, c_q, c_n;
    logic          ld_wr, ld_upd, ce;

    always_comb begin
      ld_wr  = wr_en  && (wr_chan  == CW'(g));
      ld_upd = upd_en && (upd_chan == CW'(g));
      ce     = ld_wr || ld_upd;
      a_n    = a_q;
      c_n    = c_q;
      if (ld_wr) begin
        if (wr_is_cnt) begin
          if (hi_q) c_n[AW-1:BW] = wr_byte;
          else      c_n[BW-1:0]  = wr_byte;
        end else begin
          if (hi_q) a_n[AW-1:BW] = wr_byte;
          else      a_n[BW-1:0]  = wr_byte;
        end
      end else if (ld_upd) begin
        if (reload_en && (g == RL_DST)) begin
          a_n = addr_v[RL_SRC];
          c_n = cnt_v[RL_SRC];
        end else begin
          a_n = a_q + AW'(1);
          c_n = c_q - AW'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        c_q <= '0;
      end else if (ce) begin
        a_q <= a_n;
        c_q <= c_n;
      end
    end

    assign addr_v[g] = a_q;
    assign cnt_v[g]  = c_q;
  end

  assign sel_addr  = addr_v[sel_chan];
  assign sel_cnt   = cnt_v[sel_chan];
  assign view_addr = addr_v[view_chan];
  assign view_cnt  = cnt_v[view_chan];
endmodule

// File: rtl/dmacc_seq.sv
module dmacc_seq
  import dmacc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int BW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int AW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [CW-1:0] mode_chan,
  input  logic [1:0]    mode_val,
  input  logic          step_req,
  input  logic [CW-1:0] step_chan,
  input  logic [AW-1:0] sel_cnt,
  output logic [CW-1:0] sel_chan,
  output logic          busy,
  output logic          upd_en,
  output logic          fin_now,
  output logic          tz_set,
  output logic          err_set,
  output logic          done_o,
  output logic          cdone_o,
  output logic          tc_o,
  output logic          mem_rd_req,
  input  logic          mem_rd_ack,
  input  logic [BW-1:0] mem_rdata,
  output logic          mem_wr_req,
  input  logic          mem_wr_ack,
  output logic          io_rd_req,
  input  logic          io_rd_ack,
  input  logic [BW-1:0] io_rdata,
  output logic          io_wr_req,
  input  logic          io_wr_ack,
  output logic [BW-1:0] data_o
);
  xfer_e         mode_q [NCH];
  step_st_e      st_q, st_n;
  xfer_e         xf_q, xf_n, xf_req;
  logic [CW-1:0] ch_q, ch_n;
  logic [BW-1:0] dat_q, dat_n;
  logic          tc_q, tc_n, done_q, done_n, cd_q, cd_n;
  logic          accept, m2io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) mode_q[i] <= XF_VERIFY;
    end else if (mode_wr) begin
      mode_q[mode_chan] <= xfer_e'(mode_val);
    end
  end

  always_comb begin
    busy     = (st_q != ST_IDLE);
    accept   = step_req && !busy;
    sel_chan = busy ? ch_q : step_chan;
    xf_req   = mode_q[step_chan];
    m2io     = (xf_q == XF_MEM2IO);

    mem_rd_req = (st_q == ST_RD) &&  m2io;
    io_rd_req  = (st_q == ST_RD) && !m2io;
    io_wr_req  = (st_q == ST_WR) &&  m2io;
    mem_wr_req = (st_q == ST_WR) && !m2io;

    st_n    = st_q;
    xf_n    = xf_q;
    ch_n    = ch_q;
    dat_n   = dat_q;
    tc_n    = tc_q;
    done_n  = 1'b0;
    cd_n    = 1'b0;
    tz_set  = 1'b0;
    err_set = 1'b0;
    upd_en  = 1'b0;
    fin_now = 1'b0;

    unique case (st_q)
      ST_IDLE: if (accept) begin
        ch_n   = step_chan;
        xf_n   = xf_req;
        tz_set = (xf_req != XF_BAD) && (sel_cnt == '0);
        tc_n   = tz_set;
        st_n   = (xf_req == XF_MEM2IO || xf_req == XF_IO2MEM) ? ST_RD : ST_UPD;
      end
      ST_RD: if (m2io ? mem_rd_ack : io_rd_ack) begin
        dat_n = m2io ? mem_rdata : io_rdata;
        st_n  = ST_WR;
      end
      ST_WR: if (m2io ? io_wr_ack : mem_wr_ack) begin
        st_n = ST_UPD;
      end
      ST_UPD: begin
        upd_en  = (xf_q != XF_BAD);
        err_set = (xf_q == XF_BAD);
        fin_now = upd_en && (sel_cnt == '0);
        done_n  = 1'b1;
        cd_n    = fin_now;
        tc_n    = 1'b0;
        st_n    = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      xf_q   <= XF_VERIFY;
      ch_q   <= '0;
      dat_q  <= '0;
      tc_q   <= 1'b0;
      done_q <= 1'b0;
      cd_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      xf_q   <= xf_n;
      ch_q   <= ch_n;
      dat_q  <= dat_n;
      tc_q   <= tc_n;
      done_q <= done_n;
      cd_q   <= cd_n;
    end
  end

  assign done_o  = done_q;
  assign cdone_o = cd_q;
  assign tc_o    = tc_q;
  assign data_o  = dat_q;
endmodule

// File: rtl/dmacc_status.sv
module dmacc_status #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic [CW-1:0]  set_chan,
  input  logic           err_set,
  input  logic           clr,
  output logic [NCH-1:0] bits_o,
  output logic           err_o
);
  logic [NCH-1:0] bits_q, bits_n, set_vec;
  logic           err_q, err_n, ce;

  for (genvar g = 0; g < NCH; g++) begin : g_set
    assign set_vec[g] = set_en && (set_chan == CW'(g));
  end

  always_comb begin
    ce     = clr || set_en || err_set;
    bits_n = (clr ? '0 : bits_q) | set_vec;
    err_n  = (clr ? 1'b0 : err_q) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      err_q  <= 1'b0;
    end else if (ce) begin
      bits_q <= bits_n;
      err_q  <= err_n;
    end
  end

  assign bits_o = bits_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dmac_step_unit.sv
module dmac_step_unit #(
  parameter int NCH    = 4,
  parameter int BW     = 8,
  parameter int RL_DST = 2,
  parameter int RL_SRC = 3,
  localparam int CW = $clog2(NCH),
  localparam int AW = 2 * BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [CW-1:0]  reg_chan,
  input  logic           reg_is_count,
  input  logic [BW-1:0]  reg_byte,
  input  logic           mode_wr,
  input  logic [CW-1:0]  mode_chan,
  input  logic [1:0]     mode_val,
  input  logic           autoload_en,
  input  logic           step_req,
  input  logic [CW-1:0]  step_chan,
  output logic           step_busy,
  output logic           step_done,
  output logic           chan_done,
  output logic           tc,
  input  logic           stat_rd,
  output logic [NCH-1:0] status,
  output logic           mode_err,
  input  logic [CW-1:0]  view_chan,
  output logic [AW-1:0]  view_addr,
  output logic [AW-1:0]  view_count,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd_req,
  input  logic           mem_rd_ack,
  input  logic [BW-1:0]  mem_rdata,
  output logic           mem_wr_req,
  input  logic           mem_wr_ack,
  output logic [BW-1:0]  mem_wdata,
  output logic [CW-1:0]  io_chan,
  output logic           io_rd_req,
  input  logic           io_rd_ack,
  input  logic [BW-1:0]  io_rdata,
  output logic           io_wr_req,
  input  logic           io_wr_ack,
  output logic [BW-1:0]  io_wdata
);
  logic [CW-1:0] sel_chan;
  logic [AW-1:0] sel_addr, sel_cnt;
  logic          upd_en, fin_now, tz_set, err_set, reload_en, wr_ok;
  logic [BW-1:0] data_q;

  assign wr_ok     = reg_wr && !step_busy;
  assign reload_en = fin_now && autoload_en && (sel_chan == CW'(RL_DST));

  dmacc_regfile #(.NCH(NCH), .BW(BW), .RL_DST(RL_DST), .RL_SRC(RL_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ok),
    .wr_chan   (reg_chan),
    .wr_is_cnt (reg_is_count),
    .wr_byte   (reg_byte),
    .upd_en    (upd_en),
    .reload_en (reload_en),
    .upd_chan  (sel_chan),
    .sel_chan  (sel_chan),
    .sel_addr  (sel_addr),
    .sel_cnt   (sel_cnt),
    .view_chan (view_chan),
    .view_addr (view_addr),
    .view_cnt  (view_count)
  );

  dmacc_seq #(.NCH(NCH), .BW(BW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_chan  (mode_chan),
    .mode_val   (mode_val),
    .step_req   (step_req),
    .step_chan  (step_chan),
    .sel_cnt    (sel_cnt),
    .sel_chan   (sel_chan),
    .busy       (step_busy),
    .upd_en     (upd_en),
    .fin_now    (fin_now),
    .tz_set     (tz_set),
    .err_set    (err_set),
    .done_o     (step_done),
    .cdone_o    (chan_done),
    .tc_o       (tc),
    .mem_rd_req (mem_rd_req),
    .mem_rd_ack (mem_rd_ack),
    .mem_rdata  (mem_rdata),
    .mem_wr_req (mem_wr_req),
    .mem_wr_ack (mem_wr_ack),
    .io_rd_req  (io_rd_req),
    .io_rd_ack  (io_rd_ack),
    .io_rdata   (io_rdata),
    .io_wr_req  (io_wr_req),
    .io_wr_ack  (io_wr_ack),
    .data_o     (data_q)
  );

  dmacc_status #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (tz_set),
    .set_chan (sel_chan),
    .err_set  (err_set),
    .clr      (stat_rd),
    .bits_o   (status),
    .err_o    (mode_err)
  );

  assign mem_addr  = sel_addr;
  assign io_chan   = sel_chan;
  assign mem_wdata = data_q;
  assign io_wdata  = data_q;
endmodule

// File: rtl/dmac_step_unit_chk.sv
module dmac_step_unit_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step_busy,
  input logic           step_done,
  input logic           chan_done,
  input logic           tc,
  input logic           stat_rd,
  input logic [NCH-1:0] status,
  input logic           mode_err,
  input logic           mem_rd_req,
  input logic           mem_wr_req,
  input logic           io_rd_req,
  input logic           io_wr_req
);
  // R12
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, mem_wr_req, io_rd_req, io_wr_req}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_busy |-> !(mem_rd_req || mem_wr_req || io_rd_req || io_wr_req));

  // R4
  tc_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> step_busy);

  // R4
  tc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> !tc);

  // R5
  done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done |-> step_done);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  // R11
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  // R11
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && mode_err) |=> mode_err);

  // R10
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_err) |-> step_done);
endmodule

bind dmac_step_unit dmac_step_unit_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_busy  (step_busy),
  .step_done  (step_done),
  .chan_done  (chan_done),
  .tc         (tc),
  .stat_rd    (stat_rd),
  .status     (status),
  .mode_err   (mode_err),
  .mem_rd_req (mem_rd_req),
  .mem_wr_req (mem_wr_req),
  .io_rd_req  (io_rd_req),
  .io_wr_req  (io_wr_req)
);

// File: tb/dmac_step_unit_tb.sv
`timescale 1ns/1ps
module dmac_step_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_is_count, mode_wr, autoload_en, step_req, stat_rd;
  logic [1:0]  reg_chan, mode_chan, mode_val, step_chan, view_chan, io_chan;
  logic [7:0]  reg_byte, mem_rdata, io_rdata, mem_wdata, io_wdata;
  logic        step_busy, step_done, chan_done, tc, mode_err;
  logic [3:0]  status;
  logic [15:0] view_addr, view_count, mem_addr;
  logic        mem_rd_req, mem_rd_ack, mem_wr_req, mem_wr_ack;
  logic        io_rd_req, io_rd_ack, io_wr_req, io_wr_ack;

  int n_chk = 0, n_bad = 0, n_bus = 0;
  logic [15:0] last_mw_addr;
  logic [7:0]  last_mw_data, last_iw_data;
  logic [1:0]  last_iw_chan;
  logic        seen_tc, seen_cd;

  always #2.5 clk = ~clk;

  dmac_step_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_chan(reg_chan),
    .reg_is_count(reg_is_count), .reg_byte(reg_byte), .mode_wr(mode_wr),
    .mode_chan(mode_chan), .mode_val(mode_val), .autoload_en(autoload_en),
    .step_req(step_req), .step_chan(step_chan), .step_busy(step_busy),
    .step_done(step_done), .chan_done(chan_done), .tc(tc), .stat_rd(stat_rd),
    .status(status), .mode_err(mode_err), .view_chan(view_chan),
    .view_addr(view_addr), .view_count(view_count), .mem_addr(mem_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_rdata(mem_rdata),
    .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack), .mem_wdata(mem_wdata),
    .io_chan(io_chan), .io_rd_req(io_rd_req), .io_rd_ack(io_rd_ack),
    .io_rdata(io_rdata), .io_wr_req(io_wr_req), .io_wr_ack(io_wr_ack),
    .io_wdata(io_wdata)
  );

  function automatic logic [7:0] mem_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // bus responder: acknowledges one cycle after each request appears
  initial begin
    mem_rd_ack = 0; mem_wr_ack = 0; io_rd_ack = 0; io_wr_ack = 0;
    mem_rdata = 0; io_rdata = 0;
    forever begin
      @(negedge clk);
      mem_rd_ack = mem_rd_req; mem_wr_ack = mem_wr_req;
      io_rd_ack  = io_rd_req;  io_wr_ack  = io_wr_req;
      mem_rdata  = mem_pat(mem_addr);
      io_rdata   = 8'hC0 | {6'd0, io_chan};
      if (mem_rd_req || mem_wr_req || io_rd_req || io_wr_req) n_bus++;
      if (mem_wr_req) begin last_mw_addr = mem_addr; last_mw_data = mem_wdata; end
      if (io_wr_req)  begin last_iw_chan = io_chan;  last_iw_data = io_wdata;  end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] ch, input bit is_cnt, input logic [7:0] b);
    @(negedge clk);
    reg_wr = 1; reg_chan = ch; reg_is_count = is_cnt; reg_byte = b;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic load(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
    wr_byte(ch, 0, a[7:0]); wr_byte(ch, 0, a[15:8]);
    wr_byte(ch, 1, c[7:0]); wr_byte(ch, 1, c[15:8]);
  endtask

  task automatic set_mode(input logic [1:0] ch, input logic [1:0] m);
    @(negedge clk);
    mode_wr = 1; mode_chan = ch; mode_val = m;
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic view(input logic [1:0] ch, output logic [15:0] a, output logic [15:0] c);
    view_chan = ch; #0.5; a = view_addr; c = view_count;
  endtask

  task automatic step(input logic [1:0] ch);
    @(negedge clk);
    step_req = 1; step_chan = ch;
    @(negedge clk);
    step_req = 0;
    seen_tc = 0; seen_cd = 0;
    for (int k = 0; k < 40; k++) begin
      if (step_done) begin seen_cd = chan_done; break; end
      if (tc) seen_tc = 1;
      @(negedge clk);
    end
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    logic [15:0] a, c, base, a3, c3;
    int bus0;
    rst_n = 0; reg_wr = 0; reg_chan = 0; reg_is_count = 0; reg_byte = 0;
    mode_wr = 0; mode_chan = 0; mode_val = 0; autoload_en = 0;
    step_req = 0; step_chan = 0; stat_rd = 0; view_chan = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(status == 0 && mode_err == 0, "R1 flags", {status, 3'b0, mode_err}, 0);
    chk(!tc && !step_busy && !step_done && !chan_done, "R1 outputs",
        {tc, step_busy, step_done, chan_done}, 0);
    for (int ch = 0; ch < 4; ch++) begin
      view(2'(ch), a, c);
      chk(a == 0 && c == 0, "R1 regs", {a, c}, 0);
    end

    // R2 byte order and shared pointer
    load(1, 16'hBEEF, 16'h1234);
    view(1, a, c);
    chk(a == 16'hBEEF, "R2 addr bytes", a, 16'hBEEF);
    chk(c == 16'h1234, "R2 count bytes", c, 16'h1234);
    wr_byte(1, 0, 8'hAA);   // low byte of addr
    wr_byte(1, 1, 8'hBB);   // pointer now high: count high byte
    view(1, a, c);
    chk(a == 16'hBEAA && c == 16'hBB34, "R2 shared pointer", {a, c}, {16'hBEAA, 16'hBB34});

    // R3 R4 R5 R6 R7 R8 sweep: modes 0..2, all channels, counts 0..2
    for (int m = 0; m < 3; m++) begin
      for (int ch = 0; ch < 4; ch++) begin
        set_mode(2'(ch), 2'(m));
        for (int n = 0; n < 3; n++) begin
          base = 16'(16'h00FE + 16'h1000 * ch + 16'h0100 * m + n);
          load(2'(ch), base, 16'(n));
          for (int k = 0; k <= n; k++) begin
            bus0 = n_bus;
            step(2'(ch));
            view(2'(ch), a, c);
            chk(a == 16'(base + k + 1), "R3 address", a, 16'(base + k + 1));
            chk(c == 16'(n - k - 1), "R3 count", c, 16'(n - k - 1));
            chk(seen_tc == (k == n), "R4 tc during step", seen_tc, (k == n));
            chk(seen_cd == (k == n), "R5 chan_done", seen_cd, (k == n));
            chk(!tc, "R4 tc low after step", tc, 0);
            if (m == 0)
              chk(n_bus == bus0, "R6 verify no bus", n_bus - bus0, 0);
            else if (m == 1)
              chk(last_iw_chan == 2'(ch) && last_iw_data == mem_pat(16'(base + k)),
                  "R7 mem to io", {last_iw_chan, last_iw_data}, {2'(ch), mem_pat(16'(base + k))});
            else
              chk(last_mw_addr == 16'(base + k) && last_mw_data == (8'hC0 | 8'(ch)),
                  "R8 io to mem", {last_mw_addr, last_mw_data}, {16'(base + k), 8'hC0 | 8'(ch)});
          end
          chk(status[ch] == 1'b1, "R4 status bit", status, 1 << ch);
          rd_status();
          chk(status == 0, "R11 read clears", status, 0);
        end
      end
    end

    // R9 autoload on
    set_mode(2, 0); set_mode(3, 0);
    load(3, 16'h4000, 16'h0005);
    load(2, 16'h1000, 16'h0001);
    autoload_en = 1;
    step(2);
    view(2, a, c);
    chk(a == 16'h1001 && c == 0, "R9 no reload before end", {a, c}, {16'h1001, 16'h0000});
    step(2);
    view(2, a, c);
    chk(a == 16'h4000 && c == 16'h0005 && seen_cd, "R9 reload", {a, c}, {16'h4000, 16'h0005});
    view(3, a3, c3);
    chk(a3 == 16'h4000 && c3 == 16'h0005, "R9 source kept", {a3, c3}, {16'h4000, 16'h0005});
    // R9 autoload off
    autoload_en = 0;
    load(2, 16'h1000, 16'h0000);
    step(2);
    view(2, a, c);
    chk(a == 16'h1001 && c == 16'hFFFF, "R9 no reload when off", {a, c}, {16'h1001, 16'hFFFF});
    rd_status();

    // R10 illegal mode
    set_mode(1, 3);
    load(1, 16'h2222, 16'h0000);
    bus0 = n_bus;
    step(1);
    view(1, a, c);
    chk(mode_err == 1, "R10 error flag", mode_err, 1);
    chk(a == 16'h2222 && c == 0, "R10 regs unchanged", {a, c}, {16'h2222, 16'h0000});
    chk(n_bus == bus0, "R10 no bus", n_bus - bus0, 0);
    chk(status == 0 && !seen_cd && !seen_tc, "R10 no status", status, 0);

    // R11 status read and new set on same edge
    set_mode(2, 0); set_mode(0, 0);
    load(2, 16'h0010, 16'h0000);
    step(2);   // status bit 2 set, error still set
    load(0, 16'h0020, 16'h0000);
    @(negedge clk);
    step_req = 1; step_chan = 0; stat_rd = 1;
    @(negedge clk);
    step_req = 0; stat_rd = 0;
    repeat (4) @(negedge clk);
    chk(status == 4'b0001, "R11 set wins over clear", status, 4'b0001);
    chk(mode_err == 0, "R11 error cleared", mode_err, 0);
    rd_status();

    // R12 step_req and reg_wr ignored while busy
    set_mode(0, 1);
    load(0, 16'h0300, 16'h0004);
    load(3, 16'h5555, 16'h0009);
    @(negedge clk);
    step_req = 1; step_chan = 0;
    @(negedge clk);
    step_req = 1; step_chan = 3;   // busy: ignored
    reg_wr = 1; reg_chan = 3; reg_is_count = 0; reg_byte = 8'h77;
    @(negedge clk);
    step_req = 0; reg_wr = 0;
    repeat (8) @(negedge clk);
    view(3, a, c);
    chk(a == 16'h5555 && c == 16'h0009, "R12 busy ignores", {a, c}, {16'h5555, 16'h0009});
    wr_byte(3, 0, 8'h11);          // pointer still low
    view(3, a, c);
    chk(a == 16'h5511, "R2 busy write no toggle", a, 16'h5511);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule